// File: doc/BRIEF.md
# Two-Phase Block Timeout Supervisor

This block watches the input side of a data-compression channel and raises an interrupt when the data stops arriving in time. A single 24-bit down-counter is advanced by a free-running divide-by-64 prescaler. The counter always runs in one of two phases. The idle-wait phase begins when the channel's operating mode is selected, and it limits how long the first word of a block may take to arrive. The block phase begins with that first word, and it limits how long the whole block may take.

Each phase loads its own preload value. The first accepted word of a block loads the block-complete value. The word that completes the block restores the idle-wait value. A block holds pattern count × sector count words. A preload of zero holds the counter at zero, so that phase can never time out. When the counter does expire, a sticky interrupt is set and the counter stops. It stays stopped until the mode is selected again.

Top module: `tmo_block_watchdog`

## Requirements
- R1: After reset the interrupt is low and the prescaler count is zero. The first prescaler tick falls on the 64th rising clock edge after reset is released, and every 64th edge after that.
- R2: A pulse on `mode_sel` loads the counter with `wd_preload` and enters the idle-wait phase. If no word arrives, the interrupt goes high right after the tick that takes the counter from 1 to 0. That is the `wd_preload`-th tick strictly after the load edge.
- R3: A word accepted in the idle-wait phase loads `bc_preload` and enters the block phase, as long as pattern count × sector count is greater than 1. Expiry then follows on the `bc_preload`-th tick after that edge.
- R4: In the block phase, later words that do not finish the block leave the counter untouched and do not reload it. The word that brings the accepted count to pattern count × sector count reloads `wd_preload` and returns to the idle-wait phase.
- R5: When pattern count × sector count is 0 or 1, every accepted word finishes a block. Each such word reloads `wd_preload` and never loads `bc_preload`.
- R6: A counter loaded with zero does not count and never raises the interrupt. Phase changes caused by words still load the other preload value.
- R7: The interrupt stays high until `irq_clear` is pulsed. If expiry and clear fall on the same edge, expiry wins.
- R8: After expiry the counter stays stopped and words are ignored. No further interrupt can occur until `mode_sel` is pulsed.
- R9: A word accepted on the same edge as an expiring tick takes priority. No interrupt is raised, and the word's reload from R3, R4 or R5 applies.
- R10: A `mode_sel` pulse in either running phase restarts the idle-wait phase with `wd_preload` and discards the partial block count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_sel | input | 1 | One-cycle pulse: channel mode selected, start supervision |
| word_strobe | input | 1 | One data word compressed this cycle |
| pattern_count | input | 8 | Words per sector |
| sector_count | input | 8 | Sectors per block |
| wd_preload | input | 24 | Idle-wait phase preload, zero disables |
| bc_preload | input | 24 | Block phase preload, zero disables |
| irq_clear | input | 1 | Pulse to clear the sticky interrupt |
| timeout_irq | output | 1 | Registered sticky timeout interrupt |

## Verification
The hardest case to reach is a word that lands exactly on the edge where the counter would expire. Only one clock in 64 carries a tick, so hitting that edge takes exact timing. The bench keeps its own count of edges since reset. From that count and the 64-clock period it computes the edge of every expiring tick, and it drives the word onto that exact edge. The same edge arithmetic predicts every interrupt edge. That lets the scoreboard tell a reload by a later word apart from no reload at all, since a wrong reload shifts the expiry by a whole prescaler period.

// File: rtl/tmo_pkg.sv
package tmo_pkg;
  typedef enum logic [1:0] {
    PH_IDLE    = 2'd0,
    PH_WAIT    = 2'd1,
    PH_BLOCK   = 2'd2,
    PH_EXPIRED = 2'd3
  } tmo_phase_e;
endpackage

// File: rtl/tmo_prescaler.sv
module tmo_prescaler #(
  parameter int DIV = 64
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] div_q;

  assign tick = (div_q == LAST);

  always_ff @(posedge clk) begin
    if (rst)       div_q <= '0;
    else if (tick) div_q <= '0;
    else           div_q <= div_q + 1'b1;
  end

  // R1: ticks are isolated single-cycle pulses
  a_r1_tick_isolated: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick);
endmodule

// File: rtl/tmo_word_tracker.sv
module tmo_word_tracker #(
  parameter int PAT_W = 8,
  parameter int SEC_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  input  logic             word_acc,
  input  logic [PAT_W-1:0] pattern_count,
  input  logic [SEC_W-1:0] sector_count,
  output logic             blk_done
);
  localparam int TOT_W = PAT_W + SEC_W;

  logic [TOT_W-1:0] total;
  logic [TOT_W-1:0] words_q;
  logic [TOT_W:0]   next_words;

  assign total      = TOT_W'(pattern_count) * TOT_W'(sector_count);
  assign next_words = {1'b0, words_q} + 1'b1;
  assign blk_done   = (next_words >= {1'b0, total});

  always_ff @(posedge clk) begin
    if (rst || restart)  words_q <= '0;
    else if (word_acc) begin
      if (blk_done)      words_q <= '0;
      else               words_q <= next_words[TOT_W-1:0];
    end
  end

  // R10: restart discards any partial block
  a_r10_restart_clears: assert property (@(posedge clk) disable iff (rst)
    restart |=> (words_q == '0));
endmodule

// File: rtl/tmo_timer.sv
module tmo_timer
  import tmo_pkg::*;
#(
  parameter int TMR_W = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             mode_sel,
  input  logic             word_acc,
  input  logic             blk_done,
  input  logic [TMR_W-1:0] wd_load,
  input  logic [TMR_W-1:0] bc_load,
  input  logic             irq_clear,
  output logic             active,
  output logic             timeout_irq
);
  localparam logic [TMR_W-1:0] ONE = TMR_W'(1);

  tmo_phase_e       phase_q, phase_d;
  logic [TMR_W-1:0] cnt_q, cnt_d;
  logic             irq_q, expire;

  assign active      = (phase_q == PH_WAIT) || (phase_q == PH_BLOCK);
  assign timeout_irq = irq_q;

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    expire  = 1'b0;
    if (mode_sel) begin
      cnt_d   = wd_load;
      phase_d = PH_WAIT;
    end else if (active) begin
      if (word_acc) begin
        if (blk_done) begin
          cnt_d   = wd_load;
          phase_d = PH_WAIT;
        end else if (phase_q == PH_WAIT) begin
          cnt_d   = bc_load;
          phase_d = PH_BLOCK;
        end
      end else if (tick && (cnt_q != '0)) begin
        if (cnt_q == ONE) begin
          cnt_d   = '0;
          phase_d = PH_EXPIRED;
          expire  = 1'b1;
        end else begin
          cnt_d = cnt_q - ONE;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      irq_q   <= 1'b0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
      if (expire)         irq_q <= 1'b1;
      else if (irq_clear) irq_q <= 1'b0;
    end
  end

  // R2, R10: mode selection loads the idle-wait preload
  a_r10_mode_loads_wd: assert property (@(posedge clk) disable iff (rst)
    mode_sel |=> (phase_q == PH_WAIT) && (cnt_q == $past(wd_load)));
  // R2: the interrupt can only rise after a tick
  a_r2_rise_needs_tick: assert property (@(posedge clk) disable iff (rst)
    (!irq_q && !tick) |=> !irq_q);
  // R9: an accepted word suppresses expiry
  a_r9_word_wins: assert property (@(posedge clk) disable iff (rst)
    (!irq_q && word_acc) |=> !irq_q);
  // R6: a zero count in a running phase stays zero without a word or mode
  a_r6_zero_holds: assert property (@(posedge clk) disable iff (rst)
    (active && cnt_q == '0 && !word_acc && !mode_sel) |=> (cnt_q == '0));
  // R7: sticky until cleared
  a_r7_irq_sticky: assert property (@(posedge clk) disable iff (rst)
    (irq_q && !irq_clear) |=> irq_q);
  // R8: stopped counter after expiry
  a_r8_stopped: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_EXPIRED && !mode_sel) |=> (phase_q == PH_EXPIRED) && $stable(cnt_q));
  // R4, R5: block completion restores the idle-wait preload
  a_r4_done_reload: assert property (@(posedge clk) disable iff (rst)
    (active && word_acc && blk_done && !mode_sel) |=>
      (phase_q == PH_WAIT) && (cnt_q == $past(wd_load)));
endmodule

// File: rtl/tmo_block_watchdog.sv
module tmo_block_watchdog #(
  parameter int TMR_W = 24,
  parameter int DIV   = 64,
  parameter int PAT_W = 8,
  parameter int SEC_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             mode_sel,
  input  logic             word_strobe,
  input  logic [PAT_W-1:0] pattern_count,
  input  logic [SEC_W-1:0] sector_count,
  input  logic [TMR_W-1:0] wd_preload,
  input  logic [TMR_W-1:0] bc_preload,
  input  logic             irq_clear,
  output logic             timeout_irq
);
  logic tick, active, word_acc, blk_done;

  assign word_acc = word_strobe & active;

  tmo_prescaler #(.DIV(DIV)) u_presc (
    .clk (clk),
    .rst (rst),
    .tick(tick)
  );

  tmo_word_tracker #(.PAT_W(PAT_W), .SEC_W(SEC_W)) u_track (
    .clk          (clk),
    .rst          (rst),
    .restart      (mode_sel),
    .word_acc     (word_acc),
    .pattern_count(pattern_count),
    .sector_count (sector_count),
    .blk_done     (blk_done)
  );

  tmo_timer #(.TMR_W(TMR_W)) u_timer (
    .clk        (clk),
    .rst        (rst),
    .tick       (tick),
    .mode_sel   (mode_sel),
    .word_acc   (word_acc),
    .blk_done   (blk_done),
    .wd_load    (wd_preload),
    .bc_load    (bc_preload),
    .irq_clear  (irq_clear),
    .active     (active),
    .timeout_irq(timeout_irq)
  );
endmodule

// File: tb/tmo_block_watchdog_test.sv
module tmo_block_watchdog_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        mode_sel = 1'b0;
  logic        word_strobe = 1'b0;
  logic [7:0]  pattern_count = 8'd2;
  logic [7:0]  sector_count = 8'd2;
  logic [23:0] wd_preload = 24'd0;
  logic [23:0] bc_preload = 24'd0;
  logic        irq_clear = 1'b0;
  logic        timeout_irq;

  int checks = 0;
  int failures = 0;
  int ecount = 0;
  int expq[$];
  string tagq[$];
  logic prev_irq = 1'b0;
  bit done = 1'b0;

  tmo_block_watchdog uut (
    .clk(clk), .rst(rst), .mode_sel(mode_sel), .word_strobe(word_strobe),
    .pattern_count(pattern_count), .sector_count(sector_count),
    .wd_preload(wd_preload), .bc_preload(bc_preload),
    .irq_clear(irq_clear), .timeout_irq(timeout_irq)
  );

  always #5 clk = ~clk;

  always @(posedge clk) begin
    if (rst) ecount <= 0;
    else     ecount <= ecount + 1;
  end

  function automatic int next_tick(int e);
    if (e % 64 == 63) return e + 64;
    return e - (e % 64) + 63;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor: compares each interrupt rise against the scoreboard
  always @(negedge clk) begin
    if (!rst && timeout_irq && !prev_irq) begin
      if (expq.size() == 0) begin
        check(1'b0, "unexpected-irq", ecount - 1, -1);
      end else begin
        int e;
        string t;
        e = expq.pop_front();
        t = tagq.pop_front();
        check((ecount - 1) == e, t, ecount - 1, e);
      end
    end
    prev_irq = timeout_irq;
  end

  task automatic expect_irq(int e, string tag);
    expq.push_back(e);
    tagq.push_back(tag);
  endtask

  task automatic wait_to(int p);
    @(negedge clk);
    while (ecount % 64 != p) @(negedge clk);
  endtask

  task automatic wait_until(int e);
    while (ecount <= e) @(negedge clk);
  endtask

  task automatic pulse_mode(output int m);
    mode_sel = 1'b1; m = ecount;
    @(negedge clk); mode_sel = 1'b0;
  endtask

  task automatic words(int n, output int first, output int last);
    word_strobe = 1'b1; first = ecount; last = ecount + n - 1;
    repeat (n) @(negedge clk);
    word_strobe = 1'b0;
  endtask

  task automatic clear_irq();
    irq_clear = 1'b1;
    @(negedge clk); irq_clear = 1'b0;
  endtask

  initial begin
    repeat (300000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int m, m2, w, w2, l, e;
    repeat (4) @(negedge clk);
    check(timeout_irq == 1'b0, "R1 reset irq", timeout_irq, 0);
    rst = 1'b0;

    // R1 + R2: wd=1 loaded on edge 0, first tick at edge 63
    wd_preload = 24'd1; bc_preload = 24'd7;
    pulse_mode(m);
    expect_irq(63, "R1 first tick edge");
    wait_until(70);
    repeat (100) @(negedge clk);
    check(timeout_irq == 1'b1, "R7 sticky", timeout_irq, 1);
    clear_irq();
    check(timeout_irq == 1'b0, "R7 clear", timeout_irq, 0);
    // R8: words after expiry are ignored, counter stopped
    words(3, w, l);
    repeat (300) @(negedge clk);
    check(timeout_irq == 1'b0, "R8 stopped after expiry", timeout_irq, 0);

    // R2: idle-wait expiry with wd=3
    wd_preload = 24'd3;
    wait_to(10); pulse_mode(m);
    e = next_tick(m) + 128;
    expect_irq(e, "R2 wd expiry");
    wait_until(e + 2); clear_irq();

    // R3: first word loads bc
    wd_preload = 24'd2; bc_preload = 24'd5;
    pattern_count = 8'd2; sector_count = 8'd2;
    wait_to(10); pulse_mode(m);
    wait_to(20); words(1, w, l);
    e = next_tick(w) + 64 * 4;
    expect_irq(e, "R3 bc reload");
    wait_until(e + 2); clear_irq();

    // R4: a later word in a later period does not reload
    wd_preload = 24'd3; bc_preload = 24'd3;
    wait_to(5); pulse_mode(m);
    wait_to(10); words(1, w, l);
    wait_to(10); words(1, w2, l);
    e = next_tick(w) + 128;
    expect_irq(e, "R4 no reload by later word");
    wait_until(e + 2); clear_irq();

    // R4: completion of a 4-word block restores wd
    wd_preload = 24'd2; bc_preload = 24'd9;
    wait_to(5); pulse_mode(m);
    wait_to(10); words(4, w, l);
    e = next_tick(l) + 64;
    expect_irq(e, "R4 completion reload");
    wait_until(e + 2); clear_irq();

    // R5: single-word block never loads bc
    pattern_count = 8'd1; sector_count = 8'd1;
    wait_to(5); pulse_mode(m);
    wait_to(30); words(1, w, l);
    e = next_tick(w) + 64;
    expect_irq(e, "R5 single-word block");
    wait_until(e + 2); clear_irq();

    // R6: zero wd disables, word then loads bc=2
    pattern_count = 8'd2; sector_count = 8'd2;
    wd_preload = 24'd0; bc_preload = 24'd2;
    wait_to(5); pulse_mode(m);
    repeat (300) @(negedge clk);
    check(timeout_irq == 1'b0, "R6 zero wd disabled", timeout_irq, 0);
    wait_to(20); words(1, w, l);
    e = next_tick(w) + 64;
    expect_irq(e, "R6 bc after zero wd");
    wait_until(e + 2); clear_irq();
    // R6: both zero
    bc_preload = 24'd0;
    wait_to(5); pulse_mode(m);
    wait_to(20); words(1, w, l);
    repeat (400) @(negedge clk);
    check(timeout_irq == 1'b0, "R6 zero bc disabled", timeout_irq, 0);

    // R9: word on the expiring edge wins
    wd_preload = 24'd2; bc_preload = 24'd3;
    wait_to(5); pulse_mode(m);
    e = next_tick(m) + 64;
    while (ecount < e) @(negedge clk);
    words(1, w, l);
    check(w == e, "R9 word aligned", w, e);
    @(negedge clk);
    check(timeout_irq == 1'b0, "R9 no irq on word edge", timeout_irq, 0);
    e = next_tick(w) + 128;
    expect_irq(e, "R9 bc reload after collision");
    wait_until(e + 2); clear_irq();

    // R10: re-select restarts wd; R7: clear on the expiring edge loses
    wd_preload = 24'd3; bc_preload = 24'd9;
    wait_to(5); pulse_mode(m);
    wait_to(20); words(1, w, l);
    wait_to(5); pulse_mode(m2);
    e = next_tick(m2) + 128;
    expect_irq(e, "R10 reselect reload");
    while (ecount < e) @(negedge clk);
    irq_clear = 1'b1;
    @(negedge clk); irq_clear = 1'b0;
    check(timeout_irq == 1'b1, "R7 set beats clear", timeout_irq, 1);
    repeat (5) @(negedge clk);
    clear_irq();

    repeat (10) @(negedge clk);
    check(expq.size() == 0, "scoreboard drained", expq.size(), 0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule